// File: doc/BRIEF.md
# Shift-Register FIFO with Occupancy Count

This block is a single-clock first-in first-out buffer whose storage is a chain of registers that shifts on every accepted push. A new word always enters stage 0 and every stored word moves one stage deeper. The oldest word therefore sits at stage `level - 1`, and the pop side selects it with an index taken from the occupancy counter. The block needs no write pointer and no read pointer.

With an address of `ADDR_W` bits, the buffer holds at most `2**ADDR_W - 1` words. Keeping one counter value unused lets the full and empty flags be exact. Pop data is registered: it appears on `pop_data` the cycle after a pop and holds until another pop updates it. A push into a full buffer is discarded. A pop on an empty buffer with a push in the same cycle forwards the pushed word directly to `pop_data`, and that word is not stored.

Top module: `srfifo_top`

## Requirements
- R1: A low `rst_n` or a high `clr` at a clock edge empties the buffer. After that edge `level` is 0, `empty` is 1, `full` is 0 and `pop_data` is all zeros. `clr` takes priority over a `push` or `pop` in the same cycle.
- R2: `empty` is 1 exactly when `level` is 0. `full` is 1 exactly when `level` equals `2**ADDR_W - 1`. The two flags are never 1 together.
- R3: A push without a pop on a non-full buffer raises `level` by one. A pop without a push on a non-empty buffer lowers it by one.
- R4: Words leave in the order they were pushed. The word removed by a pop appears on `pop_data` in the cycle after the pop edge.
- R5: A push and a pop in the same cycle on a buffer that is neither full nor empty are both serviced. `level` is unchanged and `pop_data` shows the oldest word.
- R6: A push while `full` is dropped, even when a pop is given in the same cycle. That pop is still serviced, so `level` falls by one, and the dropped word never appears at `pop_data`.
- R7: A pop on an empty buffer without a push leaves `level` at 0 and `pop_data` unchanged. When no pop is requested, `pop_data` is unchanged.
- R8: A pop and a push on an empty buffer in the same cycle put the pushed word on `pop_data` in the next cycle. `level` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous flush, active high |
| push | input | 1 | Push request |
| push_data | input | DATA_W | Word to push |
| pop | input | 1 | Pop request |
| pop_data | output | DATA_W | Registered word from the last pop or forwarded push |
| full | output | 1 | Buffer holds `2**ADDR_W - 1` words |
| empty | output | 1 | Buffer holds no words |
| level | output | ADDR_W | Number of stored words |

## Verification
The bench builds the block with `DATA_W = 8` and `ADDR_W = 3`, which gives a capacity of seven words. With that capacity the full boundary is reached after a few pushes, so the bench can drive a dropped push, a push with a pop while full, and a complete drain of the chain in order, all within a short run. The narrow data width still allows a distinct value for every word, so a dropped or forwarded word is identified at `pop_data` without ambiguity.

// File: rtl/srfifo_pkg.sv
// Shared definitions for the shift-register FIFO.
// Assumes: address widths from 1 to 16 bits.
package srfifo_pkg;

    // Operation chosen in one cycle by the control logic.
    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,  // nothing moves
        OP_PUSH   = 3'd1,  // store a word only
        OP_POP    = 3'd2,  // remove the oldest word only
        OP_BOTH   = 3'd3,  // store and remove; level unchanged
        OP_BYPASS = 3'd4,  // empty buffer: forward push word to output
        OP_CLEAR  = 3'd5   // flush
    } srfifo_op_e;

    // Number of storage stages for a given address width.
    function automatic int capacity(input int aw);
        return (1 << aw) - 1;
    endfunction

endpackage

// File: rtl/srfifo_chain.sv
// Storage chain. On shift_en, stage 0 takes the new word and each stage k
// takes the old contents of stage k-1. A combinational mux returns stage
// sel_idx. Contents are data only and need no reset, because the control
// logic never selects a stage that holds no valid word.
module srfifo_chain #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              shift_en,
    input  logic [DATA_W-1:0] din,
    input  logic [ADDR_W-1:0] sel_idx,
    output logic [DATA_W-1:0] dout
);
    localparam int DEPTH = srfifo_pkg::capacity(ADDR_W);

    logic [DATA_W-1:0] stage [DEPTH];

    // Stage 0 loads the incoming word on a shift.
    always_ff @(posedge clk) begin
        if (shift_en) stage[0] <= din;
    end

    // Each deeper stage takes its neighbour's word on a shift.
    for (genvar k = 1; k < DEPTH; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (shift_en) stage[k] <= stage[k-1];
        end
    end

    // Select the stage named by sel_idx; an out-of-range index returns zero.
    always_comb begin
        dout = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (sel_idx == ADDR_W'(k)) dout = stage[k];
        end
    end

endmodule

// File: rtl/srfifo_ctrl.sv
// Occupancy control. Decodes the request pins against the current level
// into one operation, keeps the level counter and derives the flags and the
// index of the oldest word (level - 1).
// Assumes: clr and rst_n are synchronous; clr outranks every request.
module srfifo_ctrl #(
    parameter int ADDR_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   push,
    input  logic                   pop,
    output srfifo_pkg::srfifo_op_e op,
    output logic [ADDR_W-1:0]      level,
    output logic [ADDR_W-1:0]      head_idx,
    output logic                   full,
    output logic                   empty
);
    import srfifo_pkg::*;

    localparam int                CAP     = capacity(ADDR_W);
    localparam logic [ADDR_W-1:0] LVL_MAX = ADDR_W'(CAP);
    localparam logic [ADDR_W-1:0] ONE     = ADDR_W'(1);

    logic [ADDR_W-1:0] level_q;
    logic              is_empty, is_full;

    assign is_empty = (level_q == '0);
    assign is_full  = (level_q == LVL_MAX);

    // Decode requests and buffer state into the cycle's operation.
    always_comb begin
        if (clr)
            op = OP_CLEAR;
        else if (is_empty)
            op = (pop && push) ? OP_BYPASS : (push ? OP_PUSH : OP_IDLE);
        else if (is_full)
            op = pop ? OP_POP : OP_IDLE;
        else if (push && pop)
            op = OP_BOTH;
        else if (push)
            op = OP_PUSH;
        else if (pop)
            op = OP_POP;
        else
            op = OP_IDLE;
    end

    // Level counter, updated only by a store or a removal that stand alone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
        end else begin
            unique case (op)
                OP_CLEAR: level_q <= '0;
                OP_PUSH:  level_q <= level_q + ONE;
                OP_POP:   level_q <= level_q - ONE;
                default:  level_q <= level_q;
            endcase
        end
    end

    assign level    = level_q;
    assign full     = is_full;
    assign empty    = is_empty;
    assign head_idx = is_empty ? '0 : (level_q - ONE);

    // R3: a lone push into a non-full buffer raises the level by one
    assert_push_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clr && !full) |=> (level == $past(level) + ONE));

    // R3: a lone pop from a non-empty buffer lowers the level by one
    assert_pop_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !clr && !empty) |=> (level == $past(level) - ONE));

    // R5: push and pop together in the middle range keep the level
    assert_both_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !clr && !full && !empty) |=> $stable(level));

    // R6: a push while full never raises the level
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !clr) |=> (level <= $past(level)));

    // R7: a pop on an empty buffer leaves it empty
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !clr) |=> empty);

endmodule

// File: rtl/srfifo_rdout.sv
// Output register. Loads the oldest stored word on a removal, loads the
// incoming word on a forward from an empty buffer, and otherwise holds.
// Clears to zero on reset or flush.
module srfifo_rdout #(
    parameter int DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  srfifo_pkg::srfifo_op_e op,
    input  logic [DATA_W-1:0]      head_word,
    input  logic [DATA_W-1:0]      push_word,
    output logic [DATA_W-1:0]      dout
);
    import srfifo_pkg::*;

    logic [DATA_W-1:0] dout_q;

    // Hold register for the last word handed out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else begin
            unique case (op)
                OP_CLEAR:        dout_q <= '0;
                OP_POP, OP_BOTH: dout_q <= head_word;
                OP_BYPASS:       dout_q <= push_word;
                default:         dout_q <= dout_q;
            endcase
        end
    end

    assign dout = dout_q;

    // R8: a forward from an empty buffer shows the pushed word next cycle
    assert_bypass_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_BYPASS) |=> (dout == $past(push_word)));

    // R7: without a removal, forward or flush the output holds
    assert_hold_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_IDLE || op == OP_PUSH) |=> $stable(dout));

endmodule

// File: rtl/srfifo_top.sv
// Shift-register FIFO top. Connects the occupancy control, the storage
// chain and the output register. Capacity is 2**ADDR_W - 1 words.
// Assumes: one clock; all requests are sampled on its rising edge.
module srfifo_top #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic              full,
    output logic              empty,
    output logic [ADDR_W-1:0] level
);
    import srfifo_pkg::*;

    srfifo_op_e        op;
    logic [ADDR_W-1:0] head_idx;
    logic [DATA_W-1:0] head_word;
    logic              shift_en;

    // The chain shifts only when a word is actually stored.
    assign shift_en = (op == OP_PUSH) || (op == OP_BOTH);

    srfifo_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .push     (push),
        .pop      (pop),
        .op       (op),
        .level    (level),
        .head_idx (head_idx),
        .full     (full),
        .empty    (empty)
    );

    srfifo_chain #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chain (
        .clk      (clk),
        .shift_en (shift_en),
        .din      (push_data),
        .sel_idx  (head_idx),
        .dout     (head_word)
    );

    srfifo_rdout #(.DATA_W(DATA_W)) u_rdout (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .head_word (head_word),
        .push_word (push_data),
        .dout      (pop_data)
    );

    // R1: a flush leaves an empty buffer with a zero output
    assert_flush_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (empty && !full && level == '0 && pop_data == '0));

    // R2: the two flags are never set together
    assert_flags_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R2: a full flag may only appear after a store
    assert_full_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(push));

endmodule

// File: tb/sim_srfifo_top.sv
module sim_srfifo_top;
    localparam int DW = 8;
    localparam int AW = 3;
    localparam int VW = 24;
    localparam int NV = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          push = 1'b0;
    logic          pop = 1'b0;
    logic [DW-1:0] push_data = '0;
    logic [DW-1:0] pop_data;
    logic          full, empty;
    logic [AW-1:0] level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 4 ns period

    srfifo_top #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .push(push),
        .push_data(push_data), .pop(pop), .pop_data(pop_data),
        .full(full), .empty(empty), .level(level)
    );

    // {clr, push, pop, push_data, level, empty, full, pop_data}
    localparam logic [VW-1:0] TBL [NV] = '{
        {1'b0,1'b1,1'b0,8'hA1, 3'd1,1'b0,1'b0, 8'h00},  // R3 push
        {1'b0,1'b1,1'b0,8'hB2, 3'd2,1'b0,1'b0, 8'h00},  // R3 push
        {1'b0,1'b1,1'b0,8'hC3, 3'd3,1'b0,1'b0, 8'h00},  // R3 push
        {1'b0,1'b0,1'b1,8'h00, 3'd2,1'b0,1'b0, 8'hA1},  // R4 oldest first
        {1'b0,1'b1,1'b1,8'hD4, 3'd2,1'b0,1'b0, 8'hB2},  // R5 push and pop
        {1'b0,1'b0,1'b1,8'h00, 3'd1,1'b0,1'b0, 8'hC3},  // R4
        {1'b0,1'b0,1'b1,8'h00, 3'd0,1'b1,1'b0, 8'hD4},  // R2 drained
        {1'b0,1'b0,1'b1,8'h00, 3'd0,1'b1,1'b0, 8'hD4},  // R7 empty pop
        {1'b0,1'b1,1'b1,8'hE5, 3'd0,1'b1,1'b0, 8'hE5},  // R8 forward
        {1'b0,1'b0,1'b0,8'h00, 3'd0,1'b1,1'b0, 8'hE5},  // R7 hold
        {1'b0,1'b1,1'b0,8'h11, 3'd1,1'b0,1'b0, 8'hE5}   // R3 push
    };

    function automatic string vec_req(input int k);
        case (k)
            3, 5:    return "R4";
            4:       return "R5";
            6:       return "R2";
            7, 9:    return "R7";
            8:       return "R8";
            default: return "R3";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive at a falling edge, then wait for the next falling edge to sample.
    task automatic cyc(input logic c, input logic w, input logic r,
                       input logic [DW-1:0] d);
        clr = c; push = w; pop = r; push_data = d;
        @(negedge clk);
        clr = 1'b0; push = 1'b0; pop = 1'b0; push_data = '0;
    endtask

    task automatic check_state(input string req, input int lvl,
                               input logic e, input logic f);
        check(req, "level", 32'(level), 32'(lvl));
        check(req, "flags", {30'd0, empty, full}, {30'd0, e, f});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_state("R1", 0, 1'b1, 1'b0);
        check("R1", "pop_data", 32'(pop_data), 32'h0);

        for (int k = 0; k < NV; k++) begin
            logic [VW-1:0] v;
            v = TBL[k];
            cyc(v[23], v[22], v[21], v[20:13]);
            check(vec_req(k), $sformatf("vec%0d level", k), 32'(level), 32'(v[12:10]));
            check(vec_req(k), $sformatf("vec%0d flags", k), {30'd0, empty, full}, {30'd0, v[9], v[8]});
            check(vec_req(k), $sformatf("vec%0d data", k), 32'(pop_data), 32'(v[7:0]));
        end

        // Fill to capacity: buffer holds 11, add 12..17.
        for (int k = 0; k < 6; k++) cyc(1'b0, 1'b1, 1'b0, 8'h12 + 8'(k));
        check_state("R2", 7, 1'b0, 1'b1);
        // R6 push while full is dropped
        cyc(1'b0, 1'b1, 1'b0, 8'h99);
        check_state("R6", 7, 1'b0, 1'b1);
        check("R6", "data held", 32'(pop_data), 32'hE5);
        // R6 push with pop while full: only the pop happens
        cyc(1'b0, 1'b1, 1'b1, 8'h88);
        check_state("R6", 6, 1'b0, 1'b0);
        check("R6", "data", 32'(pop_data), 32'h11);
        // R4 drain in order; dropped words never appear
        for (int k = 0; k < 6; k++) begin
            cyc(1'b0, 1'b0, 1'b1, 8'h00);
            check("R4", "drain data", 32'(pop_data), 32'h12 + 32'(k));
        end
        check_state("R2", 0, 1'b1, 1'b0);

        // R1 flush with a push in the same cycle
        cyc(1'b0, 1'b1, 1'b0, 8'h21);
        cyc(1'b0, 1'b1, 1'b0, 8'h22);
        cyc(1'b0, 1'b0, 1'b1, 8'h00);
        check("R4", "data", 32'(pop_data), 32'h21);
        cyc(1'b1, 1'b1, 1'b0, 8'h33);
        check_state("R1", 0, 1'b1, 1'b0);
        check("R1", "flush data", 32'(pop_data), 32'h0);
        // R7 empty pop after flush keeps zero
        cyc(1'b0, 1'b0, 1'b1, 8'h00);
        check("R7", "held data", 32'(pop_data), 32'h0);

        // R1 reset in mid-operation
        cyc(1'b0, 1'b1, 1'b0, 8'h44);
        cyc(1'b0, 1'b0, 1'b1, 8'h00);
        check("R4", "data", 32'(pop_data), 32'h44);
        cyc(1'b0, 1'b1, 1'b0, 8'h45);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_state("R1", 0, 1'b1, 1'b0);
        check("R1", "reset data", 32'(pop_data), 32'h0);
        cyc(1'b0, 1'b1, 1'b0, 8'h55);
        cyc(1'b0, 1'b1, 1'b0, 8'h66);
        cyc(1'b0, 1'b0, 1'b1, 8'h00);
        check("R4", "no stale word", 32'(pop_data), 32'h55);
        check_state("R3", 1, 1'b0, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule